// File: doc/BRIEF.md
# Line-Buffered Dot Printer Sequencer

This block drives a serial dot-matrix print head from a stream of parallel ASCII bytes. Each byte arrives with a one-cycle strobe. Printable codes are queued in an internal line store of 80 entries; every other code is dropped, except carriage return, which is not stored but closes the line. A print pass starts when the store fills up or when a carriage return arrives.

During a print pass the sequencer takes characters from the store in arrival order and holds each one on a 7-bit character-generator address port. For every dot column it issues three single-cycle strobes in turn: an output enable for the generator, a column-counter clock, and a head step. It then samples the generator's done flag. A true flag moves it to the next character; a false flag starts another column. When the store is empty it issues carriage-return, line-feed and ribbon-advance pulses on three consecutive cycles and goes back to idle. While a pass runs, `busy` is high and incoming strobes are ignored.

States: IDLE (waiting for bytes), FETCH (pop the next character, or finish if the store is empty), ENABLE, COLCLK and STEP (the three column strobes), TEST (sample the done flag), CRET, LFEED and RIBBON (the end-of-line pulses). Transitions: IDLE→FETCH on start; FETCH→ENABLE when the store holds data, FETCH→CRET when it is empty; ENABLE→COLCLK→STEP→TEST; TEST→FETCH when done is high, TEST→ENABLE when it is low; CRET→LFEED→RIBBON→IDLE.

Top module: `dotline_printer_ctrl`

## Requirements
- R1: After reset, `busy` is low and all six strobe outputs (`gen_oe`, `col_clk`, `head_step`, `cr_pulse`, `lf_pulse`, `rib_pulse`) are low.
- R2: A strobed byte in the range 0x20 to 0x7E inclusive is stored. Any other byte (0x00 to 0x1F, 0x7F to 0xFF) is never printed, and only 0x0D has any effect.
- R3: A strobed carriage return (0x0D) while idle starts a print pass: `busy` is high in the cycle after the strobe cycle.
- R4: The strobe that stores the 80th character starts a print pass without a carriage return, and all 80 characters are printed.
- R5: Characters are printed in arrival order. `gen_addr` carries the 7-bit character code and holds it steady through all of that character's column strobes.
- R6: Each column is `gen_oe`, then `col_clk`, then `head_step`, each one cycle wide, on three consecutive cycles.
- R7: `gen_done` is sampled in the cycle after `head_step`. If it is low, another column follows. If it is high, the next character is fetched, so the number of columns per character is set by the generator.
- R8: After the last character, `cr_pulse`, `lf_pulse` and `rib_pulse` fire on three consecutive cycles, one cycle each, and `busy` is low in the cycle after `rib_pulse`.
- R9: Strobes while `busy` is high are ignored. Such bytes are neither stored nor treated as line ends.
- R10: A carriage return with an empty store runs a pass with no column strobes, only the three end-of-line pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_byte | input | 8 | ASCII byte from the host |
| in_stb | input | 1 | One-cycle strobe qualifying `in_byte` |
| gen_done | input | 1 | Character generator reports its last column |
| gen_addr | output | 7 | Character code presented to the generator |
| gen_oe | output | 1 | Generator output-enable strobe |
| col_clk | output | 1 | Generator column-counter clock strobe |
| head_step | output | 1 | Print-head step strobe |
| cr_pulse | output | 1 | Carriage-return pulse |
| lf_pulse | output | 1 | Line-feed pulse |
| rib_pulse | output | 1 | Ribbon-advance pulse |
| busy | output | 1 | High for the whole print pass |

## Verification
The assertions assume that `gen_done` is meaningful only in the TEST cycle. They also assume that `in_byte` is a defined value whenever `in_strobe` is high. The bench's generator model keeps `gen_done` driven at all times. It sets `gen_done` right after the final `col_clk` of each character and clears it on the next `col_clk`, with a column count chosen per test. The bench drives bytes only on falling edges, each with a single-cycle strobe. It deliberately strobes during `busy` to exercise the ignore path, and it never leaves `in_byte` undefined while strobing.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
    localparam logic [7:0] ASCII_CR      = 8'h0D;
    localparam logic [7:0] PRINT_LOW     = 8'h20;
    localparam logic [7:0] PRINT_HIGH    = 8'h7E;
    localparam int         CHAR_W        = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ENABLE,
        ST_COLCLK,
        ST_STEP,
        ST_TEST,
        ST_CRET,
        ST_LFEED,
        ST_RIBBON
    } seq_state_t;
endpackage

// File: rtl/dlp_char_class.sv
module dlp_char_class
    import dlp_pkg::*;
(
    input  logic [7:0] byte_i,
    output logic       printable_o,
    output logic       line_end_o
);
    always_comb begin
        printable_o = (byte_i >= PRINT_LOW) && (byte_i <= PRINT_HIGH);
        line_end_o  = (byte_i == ASCII_CR);
    end
endmodule

// File: rtl/dlp_line_store.sv
module dlp_line_store #(
    parameter int DEPTH = 80,
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             rd_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             last_slot_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_i) mem[wr_ptr] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_i) wr_ptr <= bump(wr_ptr);
            if (rd_i) rd_ptr <= bump(rd_ptr);
            case ({wr_i, rd_i})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_comb begin
        rdata_o     = mem[rd_ptr];
        empty_o     = (count == '0);
        full_o      = (count == CNT_FULL);
        last_slot_o = (count == CNT_LAST);
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> !full_o);
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |-> !empty_o);
endmodule

// File: rtl/dlp_print_seq.sv
module dlp_print_seq
    import dlp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              store_empty_i,
    input  logic [CHAR_W-1:0] store_data_i,
    input  logic              gen_done_i,
    output logic              pop_o,
    output logic [CHAR_W-1:0] char_o,
    output logic              busy_o,
    output logic              oe_o,
    output logic              cclk_o,
    output logic              step_o,
    output logic              cr_o,
    output logic              lf_o,
    output logic              rib_o
);
    seq_state_t state, state_nx;
    logic [CHAR_W-1:0] char_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start_i) state_nx = ST_FETCH;
            ST_FETCH:  state_nx = store_empty_i ? ST_CRET : ST_ENABLE;
            ST_ENABLE: state_nx = ST_COLCLK;
            ST_COLCLK: state_nx = ST_STEP;
            ST_STEP:   state_nx = ST_TEST;
            ST_TEST:   state_nx = gen_done_i ? ST_FETCH : ST_ENABLE;
            ST_CRET:   state_nx = ST_LFEED;
            ST_LFEED:  state_nx = ST_RIBBON;
            ST_RIBBON: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            char_q <= '0;
        end else begin
            state <= state_nx;
            if (pop_o) char_q <= store_data_i;
        end
    end

    always_comb begin
        pop_o  = 1'b0;
        busy_o = 1'b1;
        oe_o   = 1'b0;
        cclk_o = 1'b0;
        step_o = 1'b0;
        cr_o   = 1'b0;
        lf_o   = 1'b0;
        rib_o  = 1'b0;
        unique case (state)
            ST_IDLE:   busy_o = 1'b0;
            ST_FETCH:  pop_o  = !store_empty_i;
            ST_ENABLE: oe_o   = 1'b1;
            ST_COLCLK: cclk_o = 1'b1;
            ST_STEP:   step_o = 1'b1;
            ST_TEST:   ;
            ST_CRET:   cr_o   = 1'b1;
            ST_LFEED:  lf_o   = 1'b1;
            ST_RIBBON: rib_o  = 1'b1;
            default:   busy_o = 1'b0;
        endcase
    end

    assign char_o = char_q;

    a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    a_r6_oe_then_clk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |=> (cclk_o && !oe_o));
    a_r6_clk_then_step: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_o |=> (step_o && !cclk_o));
    a_r7_step_then_idle_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !(oe_o || cclk_o || step_o || pop_o));
    a_r7_not_done_repeats: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TEST && !gen_done_i) |=> oe_o);
    a_r5_char_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk_o || step_o) |-> $stable(char_o));
    a_r8_cr_then_lf: assert property (@(posedge clk) disable iff (!rst_n)
        cr_o |=> (lf_o && !cr_o));
    a_r8_lf_then_rib: assert property (@(posedge clk) disable iff (!rst_n)
        lf_o |=> (rib_o && !lf_o));
    a_r8_rib_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rib_o |=> !busy_o);
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({oe_o, cclk_o, step_o, cr_o, lf_o, rib_o}));
endmodule

// File: rtl/dotline_printer_ctrl.sv
module dotline_printer_ctrl
    import dlp_pkg::*;
#(
    parameter int LINE_CHARS = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        in_byte,
    input  logic              in_stb,
    input  logic              gen_done,
    output logic [CHAR_W-1:0] gen_addr,
    output logic              gen_oe,
    output logic              col_clk,
    output logic              head_step,
    output logic              cr_pulse,
    output logic              lf_pulse,
    output logic              rib_pulse,
    output logic              busy
);
    logic printable, line_end;
    logic accept, store_wr, start;
    logic store_rd, store_empty, store_full, store_last;
    logic [CHAR_W-1:0] store_rdata;

    dlp_char_class u_class (
        .byte_i      (in_byte),
        .printable_o (printable),
        .line_end_o  (line_end)
    );

    always_comb begin
        accept   = in_stb && !busy;
        store_wr = accept && printable && !store_full;
        start    = accept && (line_end || (store_wr && store_last));
    end

    dlp_line_store #(
        .DEPTH (LINE_CHARS),
        .WIDTH (CHAR_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (store_wr),
        .wdata_i     (in_byte[CHAR_W-1:0]),
        .rd_i        (store_rd),
        .rdata_o     (store_rdata),
        .empty_o     (store_empty),
        .full_o      (store_full),
        .last_slot_o (store_last)
    );

    dlp_print_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .store_empty_i (store_empty),
        .store_data_i  (store_rdata),
        .gen_done_i    (gen_done),
        .pop_o         (store_rd),
        .char_o        (gen_addr),
        .busy_o        (busy),
        .oe_o          (gen_oe),
        .cclk_o        (col_clk),
        .step_o        (head_step),
        .cr_o          (cr_pulse),
        .lf_o          (lf_pulse),
        .rib_o         (rib_pulse)
    );

    a_r9_busy_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && busy) |=> $stable(store_empty) || store_rd);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(gen_oe || col_clk || head_step || cr_pulse || lf_pulse || rib_pulse));
endmodule

// File: tb/tb_dotline_printer_ctrl.sv
module tb_dotline_printer_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_stb = 1'b0;
    logic       gen_done = 1'b0;
    logic [6:0] gen_addr;
    logic gen_oe, col_clk, head_step, cr_pulse, lf_pulse, rib_pulse, busy;

    dotline_printer_ctrl dut (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_stb(in_stb),
        .gen_done(gen_done), .gen_addr(gen_addr), .gen_oe(gen_oe),
        .col_clk(col_clk), .head_step(head_step), .cr_pulse(cr_pulse),
        .lf_pulse(lf_pulse), .rib_pulse(rib_pulse), .busy(busy)
    );

    always #2 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    // generator model and event recorder
    int cols_per = 5;
    int col_cnt = 0;
    logic [7:0] printed [0:255];
    int n_print = 0, n_oe = 0, n_cclk = 0, n_step = 0, n_cr = 0, n_lf = 0, n_rib = 0;
    int ord_err = 0, addr_err = 0, eol_err = 0, late_col = 0;
    logic p_oe = 0, p_cclk = 0, p_step = 0, p_cr = 0, p_lf = 0, p_rib = 0;
    logic [6:0] cur_char = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (gen_oe) begin
                n_oe++;
                if (col_cnt == 0) begin
                    printed[n_print[7:0]] = {1'b0, gen_addr};
                    n_print++;
                    cur_char = gen_addr;
                end
            end
            if ((gen_oe || col_clk || head_step) && gen_addr != cur_char) addr_err++;
            if (col_clk) begin
                n_cclk++;
                if (!p_oe) ord_err++;
                if (col_cnt + 1 == cols_per) begin
                    col_cnt = 0;
                    gen_done <= 1'b1;
                end else begin
                    col_cnt++;
                    gen_done <= 1'b0;
                end
            end
            if (head_step) begin
                n_step++;
                if (!p_cclk) ord_err++;
            end
            if (gen_oe && p_step) ord_err++;
            if (cr_pulse) n_cr++;
            if (lf_pulse) begin n_lf++; if (!p_cr) eol_err++; end
            if (rib_pulse) begin n_rib++; if (!p_lf) eol_err++; end
            if (p_rib && busy) eol_err++;
            if ((cr_pulse || lf_pulse || rib_pulse) && (gen_oe || col_clk || head_step)) eol_err++;
            if (cr_pulse && col_cnt != 0) late_col++;
            p_oe = gen_oe; p_cclk = col_clk; p_step = head_step;
            p_cr = cr_pulse; p_lf = lf_pulse; p_rib = rib_pulse;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_byte = b;
        in_stb  = 1'b1;
        @(negedge clk);
        in_stb  = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            if (!busy) return;
            @(negedge clk);
        end
        check(0, "R8", "pass never ended", 1, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy == 0, "R1", "busy after reset", busy, 0);
        check({gen_oe, col_clk, head_step, cr_pulse, lf_pulse, rib_pulse} == 0,
              "R1", "strobes after reset",
              {gen_oe, col_clk, head_step, cr_pulse, lf_pulse, rib_pulse}, 0);
    endtask

    task automatic t_filter_and_cr();
        int p0 = n_print, o0 = n_oe, c0 = n_cclk, s0 = n_step, r0 = n_cr, e0 = ord_err;
        string txt = "Hi!";
        cols_per = 5;
        send(8'h07); send("H"); send(8'h7F); send(8'h1B);
        send("i"); send(8'h80); send(8'hFF); send("!"); send(8'h0A);
        check(busy == 0, "R2", "busy after control codes", busy, 0);
        send(8'h0D);
        check(busy == 1, "R3", "busy in cycle after CR", busy, 1);
        wait_idle();
        check(n_print - p0 == 3, "R2", "printed count", n_print - p0, 3);
        for (int i = 0; i < 3; i++)
            check(printed[p0 + i] == txt[i], "R5", "char order", printed[p0 + i], txt[i]);
        check(n_oe - o0 == 15, "R7", "oe strobes for 5 columns", n_oe - o0, 15);
        check(n_cclk - c0 == 15, "R6", "col clocks", n_cclk - c0, 15);
        check(n_step - s0 == 15, "R6", "head steps", n_step - s0, 15);
        check(ord_err == e0, "R6", "column strobe order errors", ord_err - e0, 0);
        check(n_cr - r0 == 1, "R8", "cr pulses", n_cr - r0, 1);
        check(n_lf == n_cr && n_rib == n_cr, "R8", "lf/rib count vs cr", n_rib, n_cr);
    endtask

    task automatic t_ignore_busy();
        int p0 = n_print, r0 = n_cr, o0;
        cols_per = 2;
        send("A"); send("B"); send(8'h0D);
        send("Z"); send(8'h0D); send("Q");
        check(busy == 1, "R9", "still busy after extra strobes", busy, 1);
        wait_idle();
        check(n_print - p0 == 2, "R9", "chars printed with ignored strobes", n_print - p0, 2);
        check(printed[p0] == "A" && printed[p0 + 1] == "B", "R5", "second char",
              printed[p0 + 1], "B");
        check(n_cr - r0 == 1, "R9", "ignored CR caused no extra line end", n_cr - r0, 1);
        o0 = n_oe;
        send(8'h0D);
        check(busy == 1, "R10", "busy on empty CR", busy, 1);
        wait_idle();
        check(n_oe == o0, "R10", "columns on empty line (ignored Z not stored)", n_oe - o0, 0);
        check(n_cr - r0 == 2, "R10", "line end on empty line", n_cr - r0, 2);
    endtask

    task automatic t_full_line();
        int p0 = n_print, o0 = n_oe, r0 = n_cr, bad = 0;
        cols_per = 3;
        for (int i = 0; i < 79; i++) send(8'(8'h20 + i));
        check(busy == 0, "R4", "idle with 79 stored", busy, 0);
        send(8'h7E);
        check(busy == 1, "R4", "busy after 80th char", busy, 1);
        wait_idle();
        check(n_print - p0 == 80, "R4", "chars printed from full line", n_print - p0, 80);
        for (int i = 0; i < 80; i++) begin
            logic [7:0] exp = (i == 79) ? 8'h7E : 8'(8'h20 + i);
            if (printed[p0 + i] != exp) bad++;
        end
        check(bad == 0, "R5", "order mismatches in full line", bad, 0);
        check(n_oe - o0 == 240, "R7", "columns with 3 per char", n_oe - o0, 240);
        check(n_cr - r0 == 1, "R8", "one line end", n_cr - r0, 1);
    endtask

    task automatic summary();
        check(eol_err == 0, "R8", "end-of-line sequence errors", eol_err, 0);
        check(addr_err == 0, "R5", "address changes inside a character", addr_err, 0);
        check(late_col == 0, "R7", "line end before last column", late_col, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        finished = 1;
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_filter_and_cr();
        t_ignore_busy();
        t_full_line();
        repeat (4) @(negedge clk);
        if (!finished) summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(0, "R1", "watchdog expired", 1, 0);
            summary();
        end
    end
endmodule